// File: doc/BRIEF.md
# Monochrome Tile Framebuffer with Blanking-Time Host Read

This block stores the picture for a 640x480 display as a coarse grid of 40 columns by 30 rows. Each grid cell is one bit and covers a 16x16 pixel square. A host writes one cell at a time by giving its column and row. The video side supplies the horizontal and vertical pixel counts and two active flags. The block turns them into a tile position, fetches the whole tile row in one read and picks out the bit for the current column. It then drives a registered 3-3-2 RGB pixel. A set cell is shown as black and a clear cell as white. Outside the visible area the pixel is black.

The memory has a single read path. During active display that path belongs to video. A host can ask to read one cell, and that request waits until a cycle in which the display is blanked, meaning that either active flag is low. The result comes back as the addressed bit, zero-extended to eight bits, together with a one-clock valid pulse. The host and video sides share one clock.

Top module: `tilefb_top`

## Requirements
- R1: When `wrEn` is high and the address is inside the grid (`wrCol` < 40 and `wrRow` < 30), the clock edge stores `wrBit` in cell (`wrRow`, `wrCol`). No other cell changes.
- R2: A write whose column is 40 or more, or whose row is 30 or more, leaves every cell unchanged.
- R3: When both active flags are high in cycle t, the pixel after the second following clock edge comes from cell (`vCount`/16, `hCount`/16). A set cell gives 0x00 on {red,green,blue} and a clear cell gives 0xFF.
- R4: When either active flag is low in cycle t, the pixel after the second following edge is 0x00.
- R5: If a cell is written on the same edge on which video reads it, the pixel shows the value from before the write.
- R6: A host request is captured on the edge where `hostReq` is high. If the display is blanked in the cycle after that edge, `hostValid` is high for exactly one cycle after the second edge that follows it.
- R7: A request captured during active display stays pending, and `hostValid` stays low while the display remains active. The read is served in the first blanked cycle that follows.
- R8: `hostData` bit 0 holds the addressed cell, and bits 7..1 are zero. An address outside the grid returns 0 and still raises `hostValid`.
- R9: A second request captured before the first one is served replaces it. Only the later address is read, and only one valid pulse results.
- R10: While `rst` is high, and after it is released, the pixel, `hostValid` and `hostData` are zero and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for video and host |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Cell write strobe |
| wrCol | input | 6 | Column of the cell to write |
| wrRow | input | 5 | Row of the cell to write |
| wrBit | input | 1 | Value to store |
| hActive | input | 1 | Horizontal visible-area flag |
| vActive | input | 1 | Vertical visible-area flag |
| hCount | input | 10 | Horizontal pixel count |
| vCount | input | 10 | Vertical pixel count |
| hostReq | input | 1 | Host single-cell read request |
| hostRow | input | 5 | Row of the requested cell |
| hostCol | input | 6 | Column of the requested cell |
| red | output | 3 | Red pixel component |
| green | output | 3 | Green pixel component |
| blue | output | 2 | Blue pixel component |
| hostValid | output | 1 | One-clock pulse when host data is presented |
| hostData | output | 8 | Requested cell, zero-extended |

## Verification
The hardest situations to reach are the ones where a host request meets active display. These include a request that has to wait out a long visible stretch, and a second request that overwrites a pending one before any blanking cycle arrives. The bench holds both active flags high while it issues one or two requests. It watches that `hostValid` stays low throughout, then drops the horizontal flag and checks that exactly one pulse carries the later address's cell. It also sweeps all 1200 cells through both the video path and the host path, and lines up a write and a video read of the same cell on one edge.

// File: rtl/tilefb_pkg.sv
package tilefb_pkg;
  parameter int GRID_COLS  = 40;
  parameter int GRID_ROWS  = 30;
  parameter int TILE_SHIFT = 4;
  parameter int PIX_W      = 10;
  localparam int COL_W = $clog2(GRID_COLS);
  localparam int ROW_W = $clog2(GRID_ROWS);

  // strobes from control to datapath
  typedef struct packed {
    logic             grant;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } fbCtl_t;
endpackage

// File: rtl/tilefb_ctrl.sv
module tilefb_ctrl
  import tilefb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dispActive,
  input  logic             hostReq,
  input  logic [ROW_W-1:0] hostRow,
  input  logic [COL_W-1:0] hostCol,
  output fbCtl_t           ctl
);
  logic             pending;
  logic [ROW_W-1:0] reqRow;
  logic [COL_W-1:0] reqCol;
  logic             grantNow;

  assign grantNow = pending && !dispActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      reqRow  <= '0;
      reqCol  <= '0;
    end else if (hostReq) begin
      pending <= 1'b1;
      reqRow  <= hostRow;
      reqCol  <= hostCol;
    end else if (grantNow) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    ctl.grant = grantNow;
    ctl.row   = reqRow;
    ctl.col   = reqCol;
  end
endmodule

// File: rtl/tilefb_datapath.sv
module tilefb_datapath
  import tilefb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [COL_W-1:0] wrCol,
  input  logic [ROW_W-1:0] wrRow,
  input  logic             wrBit,
  input  logic             dispActive,
  input  logic [PIX_W-1:0] hCount,
  input  logic [PIX_W-1:0] vCount,
  input  fbCtl_t           ctl,
  output logic [7:0]       pixel,
  output logic             hostValid,
  output logic [7:0]       hostData
);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(GRID_COLS);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(GRID_ROWS);

  logic [GRID_COLS-1:0] cells [GRID_ROWS];
  logic [GRID_COLS-1:0] rowData;

  logic [ROW_W-1:0] vidRow, readRow, readIdx;
  logic [COL_W-1:0] vidCol;
  logic             readOk;

  // stage-1 companions of the row read
  logic             actD, vidColOkD, hostD, hostOkD;
  logic [COL_W-1:0] vidColD, hostColD;

  assign vidRow  = ROW_W'(vCount >> TILE_SHIFT);
  assign vidCol  = COL_W'(hCount >> TILE_SHIFT);
  assign readRow = ctl.grant ? ctl.row : vidRow;
  assign readOk  = readRow < ROW_LIM;
  assign readIdx = readOk ? readRow : '0;

  // storage: one write port, one row-wide read
  always_ff @(posedge clk) begin
    if (wrEn && (wrCol < COL_LIM) && (wrRow < ROW_LIM))
      cells[wrRow][wrCol] <= wrBit;
    rowData <= readOk ? cells[readIdx] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actD      <= 1'b0;
      vidColD   <= '0;
      vidColOkD <= 1'b0;
      hostD     <= 1'b0;
      hostColD  <= '0;
      hostOkD   <= 1'b0;
    end else begin
      actD      <= dispActive;
      vidColD   <= vidCol;
      vidColOkD <= vidCol < COL_LIM;
      hostD     <= ctl.grant;
      hostColD  <= ctl.col;
      hostOkD   <= (ctl.col < COL_LIM) && (ctl.row < ROW_LIM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixel     <= 8'h00;
      hostValid <= 1'b0;
      hostData  <= 8'h00;
    end else begin
      if (actD && vidColOkD && !rowData[vidColD])
        pixel <= 8'hFF;
      else
        pixel <= 8'h00;
      hostValid <= hostD;
      if (hostD)
        hostData <= {7'b0, hostOkD & rowData[hostColD]};
    end
  end
endmodule

// File: rtl/tilefb_top.sv
module tilefb_top
  import tilefb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [COL_W-1:0] wrCol,
  input  logic [ROW_W-1:0] wrRow,
  input  logic             wrBit,
  input  logic             hActive,
  input  logic             vActive,
  input  logic [PIX_W-1:0] hCount,
  input  logic [PIX_W-1:0] vCount,
  input  logic             hostReq,
  input  logic [ROW_W-1:0] hostRow,
  input  logic [COL_W-1:0] hostCol,
  output logic [2:0]       red,
  output logic [2:0]       green,
  output logic [1:0]       blue,
  output logic             hostValid,
  output logic [7:0]       hostData
);
  fbCtl_t     ctl;
  logic       dispActive;
  logic [7:0] pixel;

  assign dispActive = hActive && vActive;

  tilefb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .dispActive(dispActive),
    .hostReq(hostReq), .hostRow(hostRow), .hostCol(hostCol), .ctl(ctl)
  );

  tilefb_datapath u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrCol(wrCol), .wrRow(wrRow),
    .wrBit(wrBit), .dispActive(dispActive), .hCount(hCount),
    .vCount(vCount), .ctl(ctl), .pixel(pixel),
    .hostValid(hostValid), .hostData(hostData)
  );

  assign {red, green, blue} = pixel;
endmodule

// File: rtl/tilefb_checks.sv
module tilefb_checks (
  input logic       clk,
  input logic       rst,
  input logic       hActive,
  input logic       vActive,
  input logic [7:0] rgb,
  input logic       hostValid,
  input logic [7:0] hostData
);
  // R4: a blanked input two cycles back yields a black pixel
  a_r4_blank_black: assert property (@(posedge clk) disable iff (rst)
    !$past(hActive && vActive, 2) |-> rgb == 8'h00);

  // R3: the pixel is only ever black or white
  a_r3_two_levels: assert property (@(posedge clk) disable iff (rst)
    (rgb == 8'h00) || (rgb == 8'hFF));

  // R7: a valid pulse can only follow a blanked cycle
  a_r7_valid_after_blank: assert property (@(posedge clk) disable iff (rst)
    hostValid |-> !$past(hActive && vActive, 2));

  // R8: the returned data is zero-extended
  a_r8_zero_extend: assert property (@(posedge clk) disable iff (rst)
    hostValid |-> hostData[7:1] == 7'b0);

  // R10: outputs are quiet the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (rgb == 8'h00) && !hostValid && (hostData == 8'h00));
endmodule

bind tilefb_top tilefb_checks chk (
  .clk(clk), .rst(rst), .hActive(hActive), .vActive(vActive),
  .rgb({red, green, blue}), .hostValid(hostValid), .hostData(hostData)
);

// File: tb/tilefb_top_test.sv
module tilefb_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, wrBit = 1'b0;
  logic [5:0] wrCol = '0, hostCol = '0;
  logic [4:0] wrRow = '0, hostRow = '0;
  logic       hActive = 1'b0, vActive = 1'b0, hostReq = 1'b0;
  logic [9:0] hCount = '0, vCount = '0;
  logic [2:0] red, green;
  logic [1:0] blue;
  logic       hostValid;
  logic [7:0] hostData;

  int checks = 0, failures = 0;
  bit model [30][40];

  always #5 clk = ~clk;

  tilefb_top uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrCol(wrCol), .wrRow(wrRow),
    .wrBit(wrBit), .hActive(hActive), .vActive(vActive), .hCount(hCount),
    .vCount(vCount), .hostReq(hostReq), .hostRow(hostRow), .hostCol(hostCol),
    .red(red), .green(green), .blue(blue), .hostValid(hostValid),
    .hostData(hostData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pat(input int r, input int c);
    return ((r * 3 + c * 5) % 7) < 3;
  endfunction

  task automatic writeCell(input int r, input int c, input bit v);
    @(negedge clk);
    wrEn = 1'b1; wrRow = 5'(r); wrCol = 6'(c); wrBit = v;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (r < 30 && c < 40) model[r][c] = v;
  endtask

  // blanked host read with exact latency checks (R6, R8)
  task automatic hostRead(input int r, input int c);
    int exp;
    exp = (r < 30 && c < 40) ? int'(model[r][c]) : 0;
    @(negedge clk);
    hActive = 1'b0; hostReq = 1'b1; hostRow = 5'(r); hostCol = 6'(c);
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    @(posedge clk); #1;
    check(hostValid == 1'b0, "R6 early", hostValid, 0);
    @(posedge clk); #1;
    check(hostValid == 1'b1, "R6 valid", hostValid, 1);
    check(hostData == 8'(exp), "R8 data", hostData, exp);
    @(posedge clk); #1;
    check(hostValid == 1'b0, "R6 pulse", hostValid, 0);
  endtask

  task automatic showPixel(input int r, input int c, input bit ha, input bit va);
    @(negedge clk);
    hActive = ha; vActive = va;
    hCount = 10'(c * 16 + (r + c) % 16);
    vCount = 10'(r * 16 + (r * 3 + c) % 16);
    @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finishRun;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int exp, pulses;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check({red, green, blue} == 8'h00, "R10 pixel", {red, green, blue}, 0);
    check(hostValid == 1'b0, "R10 valid", hostValid, 0);
    check(hostData == 8'h00, "R10 data", hostData, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(hostValid == 1'b0, "R10 no pending", hostValid, 0);

    // R1: fill every cell
    for (int r = 0; r < 30; r++)
      for (int c = 0; c < 40; c++)
        writeCell(r, c, pat(r, c));

    // R3: video sweep over every cell
    for (int r = 0; r < 30; r++)
      for (int c = 0; c < 40; c++) begin
        showPixel(r, c, 1'b1, 1'b1);
        exp = model[r][c] ? 8'h00 : 8'hFF;
        check({red, green, blue} == 8'(exp), "R3 pixel", {red, green, blue}, exp);
      end

    // R4: each flag low alone blanks a white cell
    showPixel(0, 1, 1'b0, 1'b1);
    check({red, green, blue} == 8'h00, "R4 hblank", {red, green, blue}, 0);
    showPixel(0, 1, 1'b1, 1'b0);
    check({red, green, blue} == 8'h00, "R4 vblank", {red, green, blue}, 0);

    // R1, R8: host read of every cell
    for (int r = 0; r < 30; r++)
      for (int c = 0; c < 40; c++)
        hostRead(r, c);

    // R2: out-of-grid writes, then row 0 and row 29 must be untouched
    writeCell(0, 40, !model[0][0]);
    writeCell(30, 0, !model[0][0]);
    writeCell(29, 63, !model[29][39]);
    writeCell(31, 39, !model[29][39]);
    for (int c = 0; c < 40; c++) begin
      showPixel(0, c, 1'b1, 1'b1);
      exp = model[0][c] ? 8'h00 : 8'hFF;
      check({red, green, blue} == 8'(exp), "R2 row0", {red, green, blue}, exp);
      showPixel(29, c, 1'b1, 1'b1);
      exp = model[29][c] ? 8'h00 : 8'hFF;
      check({red, green, blue} == 8'(exp), "R2 row29", {red, green, blue}, exp);
    end

    // R8: out-of-grid host reads return zero
    hostRead(31, 0);
    hostRead(0, 45);

    // R5: write and video read of the same cell on one edge
    @(negedge clk);
    hActive = 1'b1; vActive = 1'b1;
    hCount = 10'(3 * 16 + 5); vCount = 10'(2 * 16 + 7);
    wrEn = 1'b1; wrRow = 5'd2; wrCol = 6'd3; wrBit = !model[2][3];
    exp = model[2][3] ? 8'h00 : 8'hFF;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    model[2][3] = !model[2][3];
    @(posedge clk); #1;
    check({red, green, blue} == 8'(exp), "R5 old value", {red, green, blue}, exp);
    @(posedge clk); #1;
    exp = model[2][3] ? 8'h00 : 8'hFF;
    check({red, green, blue} == 8'(exp), "R5 new value", {red, green, blue}, exp);

    // R7: request during a long active stretch waits for blanking
    @(negedge clk);
    hostReq = 1'b1; hostRow = 5'd4; hostCol = 6'd9;
    @(negedge clk);
    hostReq = 1'b0;
    pulses = 0;
    repeat (20) begin
      @(posedge clk); #1;
      if (hostValid) pulses++;
    end
    check(pulses == 0, "R7 held while active", pulses, 0);
    @(negedge clk);
    hActive = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    check(hostValid == 1'b1, "R7 served", hostValid, 1);
    check(hostData == 8'(model[4][9]), "R7 data", hostData, model[4][9]);

    // R9: second request replaces the pending one
    for (int c = 0; c < 40; c++)
      if (model[6][c] != model[7][c]) begin
        @(negedge clk);
        hActive = 1'b1;
        hostReq = 1'b1; hostRow = 5'd6; hostCol = 6'(c);
        @(negedge clk);
        hostRow = 5'd7;
        @(negedge clk);
        hostReq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        hActive = 1'b0;
        pulses = 0;
        exp = -1;
        repeat (8) begin
          @(posedge clk); #1;
          if (hostValid) begin pulses++; exp = hostData; end
        end
        check(pulses == 1, "R9 single pulse", pulses, 1);
        check(exp == int'(model[7][c]), "R9 later address", exp, model[7][c]);
        break;
      end

    finishRun();
  end
endmodule